// File: doc/BRIEF.md
# Keyed Bus Permutation Array

This block sits between two halves of a protected circuit and reorders the bits of several independent 8-bit buses. Every lane keeps its own 6-bit routing key. The key picks one fixed permutation of that lane's eight input bits onto its eight output bits. The all-zero key blanks the lane, so a lane that has never been programmed drives zeros. The protected circuit only behaves as intended when every lane holds the right key. Any other key cross-wires the two halves.

Use follows two phases. First, a loader writes one key per lane. To do this it raises the write enable, puts the lane number on the address input and puts the key on the key bus. Each write lands in the addressed lane only. Once all lanes hold keys, data is applied to the input buses. The permuted data appears on the output buses through purely combinational logic.

Top module: `lane_permute_array`

## Requirements
- R1: Lane k takes input bits A..H from `dataIn[8k+0]`..`dataIn[8k+7]` and drives output bits P..W on `dataOut[8k+0]`..`dataOut[8k+7]`. Each output bit copies exactly one input bit of the same lane, as selected by that lane's stored key.
- R2: On a rising clock edge with `progEn` high, the lane numbered `progAddr` stores `progCode`, and its outputs follow the new key from that edge on. Every other lane keeps its key.
- R3: On a rising clock edge with `progEn` low, no lane key changes, whatever is on `progAddr` and `progCode`.
- R4: A lane whose key is 0 drives all eight output bits to 0, for any input.
- R5: A rising edge with `rst` high clears every lane key to 0, so all outputs read zero until the lanes are written again.
- R6: Key 9 (binary 001001) routes P..W from A,B,C,D,E,F,G,H, which is the identity.
- R7: Key 15 routes P..W from A,C,B,D,F,H,E,G. Key 31 routes them from A,B,G,H,E,F,C,D.
- R8: Key 1 routes P..W from A,B,C,E,D,F,H,G. Key 32 routes them from B,A,C,D,F,E,G,H.
- R9: Key 2 routes P..W from E,H,F,G,A,B,C,D. Key 18 routes them from B,C,D,E,F,G,H,A, a rotation by one place.
- R10: Every other non-zero key c uses a computed routing. Output j (P=0 .. W=7) takes input number (m*j + s) mod 8, where m = 2*c[1:0]+1, s = c[4:2] + 4*c[5], and A=0 .. H=7.
- R11: The outputs respond to a change on the input buses within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for key writes and reset |
| rst | input | 1 | Synchronous active-high reset; clears all keys |
| progEn | input | 1 | Key write enable |
| progAddr | input | ADDR_W (2) | Lane number to write |
| progCode | input | 6 | Key value to write |
| dataIn | input | LANES*8 (32) | Input buses, lane 0 in the low byte |
| dataOut | output | LANES*8 (32) | Permuted output buses, lane 0 in the low byte |

## Verification
The bench builds the block with its default of four lanes and a 2-bit address. With this size every address value maps to a real lane, so the bench can reach every decoder output and check that each write stays in its own lane. Across the run, all 64 key values are written into rotating lanes under random data. This covers the blanking key, each named routing and the computed family. Resets land partway through the run, and writes are attempted with the enable low.

// File: rtl/lane_permute_pkg.sv
package lane_permute_pkg;
  localparam int LANE_W = 8;
  localparam int SEL_W  = $clog2(LANE_W);
  localparam int CODE_W = 6;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LANE_W-1:0][SEL_W-1:0] route_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic  anyLoad;
    code_t code;
  } prog_strobe_t;

  // Source index for every output bit of a lane, for a given key.
  function automatic route_t routeFor(input code_t c);
    route_t r;
    int mul, ofs;
    mul = 2 * int'(c[1:0]) + 1;
    ofs = int'(c[4:2]) + 4 * int'(c[5]);
    for (int j = 0; j < LANE_W; j++) r[j] = SEL_W'((mul * j + ofs) % LANE_W);
    case (c)
      6'd9:  r = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
      6'd15: r = {3'd6, 3'd4, 3'd7, 3'd5, 3'd3, 3'd1, 3'd2, 3'd0};
      6'd31: r = {3'd3, 3'd2, 3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0};
      6'd1:  r = {3'd6, 3'd7, 3'd5, 3'd3, 3'd4, 3'd2, 3'd1, 3'd0};
      6'd32: r = {3'd7, 3'd6, 3'd4, 3'd5, 3'd3, 3'd2, 3'd0, 3'd1};
      6'd2:  r = {3'd3, 3'd2, 3'd1, 3'd0, 3'd6, 3'd5, 3'd7, 3'd4};
      6'd18: r = {3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1};
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lane_permute_ctrl.sv
module lane_permute_ctrl
  import lane_permute_pkg::*;
#(
  parameter int LANES  = 4,
  localparam int ADDR_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              progEn,
  input  logic [ADDR_W-1:0] progAddr,
  input  code_t             progCode,
  output logic [LANES-1:0]  laneLoad,
  output prog_strobe_t      strobe
);
  // Address decoder: one-hot lane load, all low when disabled.
  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign laneLoad[i] = progEn && (progAddr == ADDR_W'(i));
  end

  always_comb begin
    strobe.anyLoad = progEn;
    strobe.code    = progCode;
  end
endmodule

// File: rtl/lane_permute_datapath.sv
module lane_permute_datapath
  import lane_permute_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          laneLoad,
  input  prog_strobe_t              strobe,
  input  logic [LANES*LANE_W-1:0]   dataIn,
  output logic [LANES*LANE_W-1:0]   dataOut,
  output logic [LANES-1:0][CODE_W-1:0] laneCodes
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    code_t  keyQ;
    route_t route;

    always_ff @(posedge clk) begin
      if (rst)                                keyQ <= '0;
      else if (strobe.anyLoad && laneLoad[l]) keyQ <= strobe.code;
    end

    assign route        = routeFor(keyQ);
    assign laneCodes[l] = keyQ;

    for (genvar j = 0; j < LANE_W; j++) begin : g_bit
      assign dataOut[l*LANE_W + j] =
        (keyQ != '0) && dataIn[l*LANE_W + int'(route[j])];
    end
  end
endmodule

// File: rtl/lane_permute_array.sv
module lane_permute_array
  import lane_permute_pkg::*;
#(
  parameter int LANES  = 4,
  localparam int ADDR_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BUS_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progEn,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [CODE_W-1:0] progCode,
  input  logic [BUS_W-1:0]  dataIn,
  output logic [BUS_W-1:0]  dataOut
);
  logic [LANES-1:0]             laneLoad;
  prog_strobe_t                 strobe;
  logic [LANES-1:0][CODE_W-1:0] laneCodes;

  lane_permute_ctrl #(.LANES(LANES)) ctrl_i (
    .progEn(progEn), .progAddr(progAddr), .progCode(progCode),
    .laneLoad(laneLoad), .strobe(strobe)
  );

  lane_permute_datapath #(.LANES(LANES)) dp_i (
    .clk(clk), .rst(rst), .laneLoad(laneLoad), .strobe(strobe),
    .dataIn(dataIn), .dataOut(dataOut), .laneCodes(laneCodes)
  );
endmodule

// File: rtl/lane_permute_array_chk.sv
module lane_permute_array_chk
  import lane_permute_pkg::*;
#(
  parameter int LANES  = 4,
  localparam int ADDR_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         progEn,
  input logic [ADDR_W-1:0]            progAddr,
  input logic [CODE_W-1:0]            progCode,
  input logic [LANES*LANE_W-1:0]      dataIn,
  input logic [LANES*LANE_W-1:0]      dataOut,
  input logic [LANES-1:0][CODE_W-1:0] laneCodes
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (laneCodes == '0)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !progEn |=> $stable(laneCodes)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    progEn |=> (laneCodes[$past(progAddr)] == $past(progCode))); // R2

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_ZERO_BLANKS: assert property (@(posedge clk) disable iff (rst)
      (laneCodes[l] == '0) |-> (dataOut[l*LANE_W +: LANE_W] == '0)); // R4

    AST_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
      (laneCodes[l] != '0) |->
        ($countones(dataOut[l*LANE_W +: LANE_W]) ==
         $countones(dataIn[l*LANE_W +: LANE_W]))); // R1
  end
endmodule

bind lane_permute_array lane_permute_array_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .progEn(progEn), .progAddr(progAddr),
  .progCode(progCode), .dataIn(dataIn), .dataOut(dataOut),
  .laneCodes(laneCodes)
);

// File: tb/lane_permute_array_tb.sv
module lane_permute_array_tb_top;
  localparam int LANES = 4;
  localparam int AW    = 2;
  localparam int BW    = LANES * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          progEn = 1'b0;
  logic [AW-1:0] progAddr = '0;
  logic [5:0]    progCode = '0;
  logic [BW-1:0] dataIn = '0;
  logic [BW-1:0] dataOut;

  int checks = 0;
  int fails  = 0;
  int model [LANES];

  always #4 clk = ~clk;

  lane_permute_array #(.LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .progEn(progEn), .progAddr(progAddr),
    .progCode(progCode), .dataIn(dataIn), .dataOut(dataOut)
  );

  // Reference key store, updated on each rising edge.
  always @(posedge clk) begin
    if (rst) for (int l = 0; l < LANES; l++) model[l] = 0;
    else if (progEn) model[int'(progAddr)] = int'(progCode);
  end

  function automatic string namedRoute(int c);
    case (c)
      9:  return "ABCDEFGH";
      15: return "ACBDFHEG";
      31: return "ABGHEFCD";
      1:  return "ABCEDFHG";
      32: return "BACDFEGH";
      2:  return "EHFGABCD";
      18: return "BCDEFGHA";
      default: return "";
    endcase
  endfunction

  function automatic string tagFor(int c);
    case (c)
      0: return "R4";
      9: return "R6";
      15, 31: return "R7";
      1, 32: return "R8";
      2, 18: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [7:0] expectLane(int c, logic [7:0] din);
    logic [7:0] res;
    string s;
    int src;
    res = '0;
    if (c == 0) return res;
    s = namedRoute(c);
    for (int j = 0; j < 8; j++) begin
      if (s.len() == 8) src = int'(s[j]) - int'("A");
      else src = ((2 * (c % 4) + 1) * j + ((c / 4) % 8) + 4 * (c / 32)) % 8;
      res[j] = din[src];
    end
    return res;
  endfunction

  task automatic checkAll(string extra);
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] exp;
      logic [7:0] got;
      exp = expectLane(model[l], dataIn[l*8 +: 8]);
      got = dataOut[l*8 +: 8];
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s R1 R2 R11 %s lane %0d key %0d: actual %h expected %h",
                 tagFor(model[l]), extra, l, model[l], got, exp);
      end
    end
  endtask

  // Drive at the falling edge, check combinational outputs 2 ns later.
  task automatic step(logic en, int addr, int code, logic [BW-1:0] d, string extra);
    @(negedge clk);
    progEn   = en;
    progAddr = AW'(addr);
    progCode = 6'(code);
    dataIn   = d;
    #2;
    checkAll(extra);
  endtask

  initial begin
    // R5: reset state, outputs zero under nonzero data.
    step(1'b0, 0, 0, 32'hFFFF_FFFF, "R5 reset");
    step(1'b1, 1, 9, 32'hA5A5_5A5A, "R5 reset");
    step(1'b0, 0, 0, 32'h1234_5678, "R5 reset");
    rst = 1'b0;
    step(1'b0, 0, 0, 32'hDEAD_BEEF, "R5 after reset");
    // Named keys in each lane; R2 writes one lane at a time.
    step(1'b1, 0, 9,  32'h0F0F_0F0F, "R2");
    step(1'b1, 1, 15, 32'h3C69_A5F0, "R2");
    step(1'b1, 2, 31, 32'h8142_2418, "R2");
    step(1'b1, 3, 18, 32'h0102_0408, "R2");
    step(1'b0, 0, 0,  32'h8040_2010, "R11");
    step(1'b1, 0, 1,  32'h1357_9BDF, "R2");
    step(1'b1, 1, 32, 32'h2468_ACE0, "R2");
    step(1'b1, 2, 2,  32'hF00F_55AA, "R2");
    step(1'b0, 3, 0,  32'h0123_4567, "R3 idle");
    // R3: enable low with noisy address and key.
    for (int i = 0; i < 16; i++)
      step(1'b0, i % 4, (i * 7 + 3) % 64, $urandom, "R3 idle");
    // Sweep all 64 keys through rotating lanes.
    for (int c = 0; c < 64; c++) begin
      step(1'b1, c % 4, c, $urandom, "sweep");
      step(1'b0, (c + 1) % 4, 63 - c, $urandom, "R11 sweep");
      step(1'b0, (c + 2) % 4, c ^ 21, {BW{1'b1}}, "R11 sweep");
    end
    // R4: blank a programmed lane again.
    step(1'b1, 2, 0, 32'hFFFF_FFFF, "R4 reblank");
    step(1'b0, 0, 0, 32'hFFFF_FFFF, "R4 reblank");
    // Mid-run reset, R5.
    rst = 1'b1;
    step(1'b1, 3, 9, 32'hC3C3_C3C3, "R5 midrun");
    step(1'b0, 0, 0, 32'hFFFF_FFFF, "R5 midrun");
    rst = 1'b0;
    step(1'b1, 0, 9, 32'h5555_AAAA, "R5 R2 reprogram");
    step(1'b0, 0, 0, 32'hAAAA_5555, "R5 R2 reprogram");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule